// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It uses a page directory and page tables held in memory. A request brings the linear address, a read or write flag and a user or supervisor flag. A control input carries the paging enable and the frame number of the directory.

When paging is off, the address goes straight through. When paging is on, the walker takes these steps:
- It reads the directory entry selected by the top ten address bits.
- It reads the table entry selected by the next ten bits.
- It checks presence and permissions at both levels.
- It writes an entry back when the accessed flag, or for a write the dirty flag, must be set.
- It reports the frame plus the 12-bit page offset, or a page fault.

Entries are fetched through a simple memory port. Read data arrives one cycle after a read strobe, and a write strobe completes in its own cycle. The block takes a new request only while idle. Each result is signalled by a single-cycle `done` pulse together with `fault`.

Top module: `pt_walker`

## Requirements
- R1: With `ctl_pg_en` low, an accepted request completes with `done` high in the cycle after acceptance, `fault` low, `phys_addr` equal to `req_lin`, and no memory access.
- R2: The directory entry is read from address {`ctl_dir_base`, lin[31:22], 2'b00}. The table entry is read from {directory entry[31:12], lin[21:12], 2'b00}. The physical address is {table entry[31:12], lin[11:0]}.
- R3: An entry with bit 0 (present) clear ends the walk with a fault. A non-present directory entry causes no table read.
- R4: A write access faults when bit 1 (writable) is clear in the directory or the table entry. A supervisor read of the same read-only page succeeds.
- R5: A user access faults when bit 2 (user) is clear in the directory or the table entry. A supervisor access to that page succeeds.
- R6: An entry used by a successful walk step with bit 5 (accessed) clear is written back to its own address with bit 5 set and all other bits unchanged.
- R7: A successful write access sets bit 6 (dirty) in the table entry it writes back. Bit 6 is never set in a directory entry.
- R8: No write-back occurs for an entry that faults, or whose needed flags are already set. A walk with no write-backs finishes in five cycles and each write-back adds one cycle.
- R9: `req_ready` is high only while idle. A request presented while busy is ignored and yields no extra result.
- R10: `done` is a single-cycle pulse, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle, request taken |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| ctl_pg_en | input | 1 | Paging enable |
| ctl_dir_base | input | 20 | Frame number of the page directory |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Page fault, valid with `done` |
| phys_addr | output | 32 | Physical address, valid with `done` and no fault |
| mem_rd | output | 1 | Entry read strobe |
| mem_wr | output | 1 | Entry write strobe |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry write data |
| mem_rdata | input | 32 | Entry read data, one cycle after `mem_rd` |

## Verification
The walk is driven with the following patterns:
- A supervisor read of a never-touched page, where both levels need the accessed flag.
- A write to the same page, where only the dirty flag is missing.
- A repeat write, where nothing is missing.

The cycle counts and the entry words in memory tell these three cases apart. Fault patterns cover the following, each repeated as a supervisor read to show that the fault comes from the flag and not from the page:
- a non-present directory entry and a non-present table entry;
- a read-only page and a read-only directory;
- a supervisor-only directory.

The read count separates directory-level faults from table-level faults. A pass-through request and a request presented while the walker is busy complete the set.

// File: rtl/pgw_pkg.sv
// Shared constants and state encoding for the page table walker.
// Assumes entries are one address word wide with flags in the low bits.
package pgw_pkg;
    localparam int FLAG_P = 0;  // present
    localparam int FLAG_W = 1;  // writable
    localparam int FLAG_U = 2;  // user accessible
    localparam int FLAG_A = 5;  // accessed
    localparam int FLAG_D = 6;  // dirty

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_CHK,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_CHK,
        ST_TBL_WB,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/pgw_addr_gen.sv
// Address arithmetic for the walk: the directory entry address, the table
// entry address and the final physical address.
// Assumes PAGE_SHIFT = IDX_W + 2, so that index plus byte offset fills a page.
module pgw_addr_gen #(
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = PAGE_SHIFT - 2,
    localparam int ADDR_W    = PAGE_SHIFT + 2 * IDX_W,
    localparam int FRAME_W   = ADDR_W - PAGE_SHIFT
) (
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [FRAME_W-1:0] page_frame,
    input  logic [ADDR_W-1:0]  lin,
    input  logic               bypass,
    output logic [ADDR_W-1:0]  dir_entry_addr,
    output logic [ADDR_W-1:0]  tbl_entry_addr,
    output logic [ADDR_W-1:0]  phys
);
    localparam int HI_LSB = PAGE_SHIFT + IDX_W;

    // Form the entry addresses and the translated or bypassed result.
    always_comb begin
        dir_entry_addr = {dir_frame, lin[ADDR_W-1:HI_LSB], 2'b00};
        tbl_entry_addr = {tbl_frame, lin[HI_LSB-1:PAGE_SHIFT], 2'b00};
        phys           = bypass ? lin : {page_frame, lin[PAGE_SHIFT-1:0]};
    end
endmodule

// File: rtl/pgw_entry_eval.sv
// Checks one fetched entry against the access type and builds its
// write-back value. IS_LEAF selects table-level behaviour (dirty flag).
// Assumes supervisor writes to read-only pages fault as user writes do.
module pgw_entry_eval
    import pgw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              is_write,
    input  logic              is_user,
    output logic              deny,
    output logic              need_wb,
    output logic [ADDR_W-1:0] wb_val
);
    logic mark_dirty;

    generate
        if (IS_LEAF) begin : g_leaf
            // Only a table entry records a write.
            always_comb mark_dirty = is_write;
        end else begin : g_dir
            // Directory entries never get the dirty flag.
            always_comb mark_dirty = 1'b0;
        end
    endgenerate

    // Decide fault, update need and updated entry value.
    always_comb begin
        deny = !entry[FLAG_P]
             || (is_write && !entry[FLAG_W])
             || (is_user && !entry[FLAG_U]);
        need_wb = !entry[FLAG_A] || (mark_dirty && !entry[FLAG_D]);
        wb_val  = entry;
        wb_val[FLAG_A] = 1'b1;
        if (mark_dirty) wb_val[FLAG_D] = 1'b1;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. It takes one request while idle, walks the
// directory and the table through a memory port with one-cycle read
// latency, writes back flag updates, and pulses done with fault or the
// physical address. Assumes the memory accepts a write in its strobe cycle.
module pt_walker
    import pgw_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = PAGE_SHIFT - 2,
    localparam int ADDR_W    = PAGE_SHIFT + 2 * IDX_W,
    localparam int FRAME_W   = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               ctl_pg_en,
    input  logic [FRAME_W-1:0] ctl_dir_base,
    output logic               done,
    output logic               fault,
    output logic [ADDR_W-1:0]  phys_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic [ADDR_W-1:0]  mem_rdata
);
    localparam int NLVL = 2;

    walk_st_e           state_q;
    logic [ADDR_W-1:0]  lin_q;
    logic [FRAME_W-1:0] base_q;
    logic               wr_q, usr_q, bypass_q, fault_q;
    logic [ADDR_W-1:0]  pde_q, pte_q;

    logic [NLVL-1:0]    lvl_deny, lvl_need;
    logic [ADDR_W-1:0]  lvl_wb [NLVL];
    logic [ADDR_W-1:0]  dir_addr, tbl_addr;

    // One evaluator per level; level 1 is the table (leaf) level.
    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_lvl
            pgw_entry_eval #(
                .ADDR_W (ADDR_W),
                .IS_LEAF(g == NLVL - 1)
            ) u_eval (
                .entry   (mem_rdata),
                .is_write(wr_q),
                .is_user (usr_q),
                .deny    (lvl_deny[g]),
                .need_wb (lvl_need[g]),
                .wb_val  (lvl_wb[g])
            );
        end
    endgenerate

    pgw_addr_gen #(.PAGE_SHIFT(PAGE_SHIFT)) u_addr (
        .dir_frame     (base_q),
        .tbl_frame     (pde_q[ADDR_W-1:PAGE_SHIFT]),
        .page_frame    (pte_q[ADDR_W-1:PAGE_SHIFT]),
        .lin           (lin_q),
        .bypass        (bypass_q),
        .dir_entry_addr(dir_addr),
        .tbl_entry_addr(tbl_addr),
        .phys          (phys_addr)
    );

    // Walk sequencer: capture the request, step through the levels, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lin_q    <= '0;
            base_q   <= '0;
            wr_q     <= 1'b0;
            usr_q    <= 1'b0;
            bypass_q <= 1'b0;
            fault_q  <= 1'b0;
            pde_q    <= '0;
            pte_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    lin_q    <= req_lin;
                    base_q   <= ctl_dir_base;
                    wr_q     <= req_write;
                    usr_q    <= req_user;
                    bypass_q <= !ctl_pg_en;
                    fault_q  <= 1'b0;
                    state_q  <= ctl_pg_en ? ST_DIR_RD : ST_DONE;
                end
                ST_DIR_RD: state_q <= ST_DIR_CHK;
                ST_DIR_CHK: begin
                    pde_q <= lvl_wb[0];
                    if (lvl_deny[0]) begin
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= lvl_need[0] ? ST_DIR_WB : ST_TBL_RD;
                    end
                end
                ST_DIR_WB: state_q <= ST_TBL_RD;
                ST_TBL_RD: state_q <= ST_TBL_CHK;
                ST_TBL_CHK: begin
                    pte_q <= lvl_wb[1];
                    if (lvl_deny[1]) begin
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= lvl_need[1] ? ST_TBL_WB : ST_DONE;
                    end
                end
                ST_TBL_WB: state_q <= ST_DONE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port and the result outputs from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        fault     = done && fault_q;
        mem_rd    = (state_q == ST_DIR_RD) || (state_q == ST_TBL_RD);
        mem_wr    = (state_q == ST_DIR_WB) || (state_q == ST_TBL_WB);
        mem_addr  = ((state_q == ST_DIR_RD) || (state_q == ST_DIR_WB))
                    ? dir_addr : tbl_addr;
        mem_wdata = (state_q == ST_DIR_WB) ? pde_q : pte_q;
    end
endmodule

// File: rtl/pt_walker_checker.sv
// Port-level properties of the walker, bound to every pt_walker instance.
module pt_walker_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_lin,
    input logic              ctl_pg_en,
    input logic              done,
    input logic              fault,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata
);
    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !ctl_pg_en) |=> (done && !fault && phys_addr == $past(req_lin))); // R1
    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00)); // R2
    AST_WB_HAS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_wdata[5]); // R6
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10
endmodule

bind pt_walker pt_walker_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_lin  (req_lin),
    .ctl_pg_en(ctl_pg_en),
    .done     (done),
    .fault    (fault),
    .phys_addr(phys_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/pt_walker_tb_top.sv
// Directed bench: a small word memory holds one directory and two tables.
module pt_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic        ctl_pg_en = 1'b0;
    logic [31:0] req_lin = '0;
    logic [19:0] ctl_dir_base = 20'h00001;
    logic        req_ready, done, fault, mem_rd, mem_wr;
    logic [31:0] phys_addr, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [4096];

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0, lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
        .ctl_pg_en(ctl_pg_en), .ctl_dir_base(ctl_dir_base), .done(done),
        .fault(fault), .phys_addr(phys_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle read latency, write in strobe cycle, counters.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[13:2]];
            rd_cnt = rd_cnt + 1;
        end
        if (mem_wr) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] la(input int d, input int t, input int o);
        return (32'(d) << 22) | (32'(t) << 12) | 32'(o);
    endfunction

    // Issue one request and wait for its done pulse; lat counts cycles.
    task automatic walk(input logic [31:0] lin, input logic wr, input logic usr);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset;
        chk("R9", "ready after reset", 32'(req_ready), 1);
        chk("R10", "done after reset", 32'(done), 0);
        chk("R10", "strobes after reset", {30'd0, mem_rd, mem_wr}, 0);
    endtask

    task automatic t_bypass;
        ctl_pg_en = 1'b0;
        walk(32'hDEADBEEF, 1'b1, 1'b1);
        chk("R1", "bypass latency", lat, 0);
        chk("R1", "bypass phys", phys_addr, 32'hDEADBEEF);
        chk("R1", "bypass fault", 32'(fault), 0);
        chk("R1", "bypass mem reads", rd_cnt, 0);
        @(negedge clk);
        chk("R10", "done pulse width", 32'(done), 0);
        ctl_pg_en = 1'b1;
    endtask

    task automatic t_first_touch;
        walk(la(0, 5, 'h123), 1'b0, 1'b0);
        chk("R2", "first-touch phys", phys_addr, 32'hABCDE123);
        chk("R2", "first-touch fault", 32'(fault), 0);
        chk("R6", "pde accessed set", mem[1024], 32'h0000_2027);
        chk("R6", "pte accessed set, no dirty on read", mem[2048+5], 32'hABCDE027);
        chk("R8", "two write-backs latency", lat, 6);
    endtask

    task automatic t_write_dirty;
        walk(la(0, 5, 'hFFF), 1'b1, 1'b1);
        chk("R7", "write phys", phys_addr, 32'hABCDEFFF);
        chk("R7", "pte dirty set", mem[2048+5], 32'hABCDE067);
        chk("R7", "pde not dirtied", mem[1024], 32'h0000_2027);
        chk("R8", "one write-back", wr_cnt, 1);
        walk(la(0, 5, 'h004), 1'b1, 1'b0);
        chk("R8", "no write-back when flags set", wr_cnt, 0);
        chk("R8", "plain walk latency", lat, 4);
    endtask

    task automatic t_not_present;
        walk(la(2, 0, 0), 1'b0, 1'b0);
        chk("R3", "pde absent fault", 32'(fault), 1);
        chk("R3", "pde absent reads", rd_cnt, 1);
        chk("R8", "pde absent writes", wr_cnt, 0);
        walk(la(0, 7, 0), 1'b0, 1'b0);
        chk("R3", "pte absent fault", 32'(fault), 1);
        chk("R3", "pte absent reads", rd_cnt, 2);
        chk("R8", "pte absent entry untouched", mem[2048+7], 0);
    endtask

    task automatic t_write_protect;
        walk(la(0, 6, 0), 1'b1, 1'b1);
        chk("R4", "write to read-only pte", 32'(fault), 1);
        chk("R8", "read-only pte unchanged", mem[2048+6], 32'h12345025);
        walk(la(0, 6, 'hABC), 1'b0, 1'b0);
        chk("R4", "read of read-only page ok", 32'(fault), 0);
        chk("R4", "read of read-only page phys", phys_addr, 32'h12345ABC);
        walk(la(1, 1, 0), 1'b1, 1'b0);
        chk("R4", "write through read-only pde", 32'(fault), 1);
        chk("R4", "fault at directory reads", rd_cnt, 1);
        walk(la(1, 1, 'h010), 1'b0, 1'b0);
        chk("R4", "read through read-only pde", phys_addr, 32'h77777010);
    endtask

    task automatic t_user;
        walk(la(3, 1, 4), 1'b0, 1'b1);
        chk("R5", "user through supervisor pde", 32'(fault), 1);
        walk(la(3, 1, 4), 1'b0, 1'b0);
        chk("R5", "supervisor same page fault", 32'(fault), 0);
        chk("R5", "supervisor same page phys", phys_addr, 32'h77777004);
        walk(la(0, 9, 0), 1'b0, 1'b1);
        chk("R5", "user to supervisor pte", 32'(fault), 1);
    endtask

    task automatic t_busy;
        int extra;
        @(negedge clk);
        req_valid = 1'b1; req_lin = la(0, 5, 'h2A0); req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_lin = 32'hFFFF_FFFF; req_write = 1'b1; req_user = 1'b1;
        chk("R9", "ready while busy", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", "busy request result", phys_addr, 32'hABCDE2A0);
        chk("R9", "busy request fault", 32'(fault), 0);
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9", "extra results", extra, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[1024+0] = 32'h0000_2007;   // P W U, A clear
        mem[1024+1] = 32'h0000_3025;   // P U A, read-only
        mem[1024+3] = 32'h0000_3023;   // P W A, supervisor only
        mem[2048+5] = 32'hABCDE007;
        mem[2048+6] = 32'h12345025;    // P U A, read-only
        mem[2048+9] = 32'h9999_9023;   // P W A, supervisor only
        mem[3072+1] = 32'h7777_7027;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_first_touch();
        t_write_dirty();
        t_not_present();
        t_write_protect();
        t_user();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule